// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block decides whether a conditional branch in a five-stage in-order pipeline should be treated as taken. The fetch stage presents the branch address and the signed offset to its target. The block answers combinationally with a single taken or not-taken bit. Later, the execute stage reports the resolved outcome of a branch together with its address. The block uses that report to train its history table.

A two-bit mode input selects the strategy while the block runs. The two fixed strategies always predict not taken or always predict taken. A direction heuristic predicts taken only for branches that jump backward. The fourth strategy is a direct-mapped history table. Each entry of that table carries a valid bit, the upper address bits of the branch that owns it, and a two-bit saturating confidence counter.

Top module: `bp_dir_predictor`

## Requirements
- R1: With mode 2'b00 the prediction is always 0 (not taken).
- R2: With mode 2'b01 the prediction is always 1 (taken).
- R3: With mode 2'b10 the prediction is 1 exactly when pred_pc + pred_offset is a lower address than pred_pc. A zero or positive offset predicts 0.
- R4: With mode 2'b11, a lookup predicts 0 when the entry at index pred_pc[11:0] is invalid. After every reset, all 4096 entries are invalid.
- R5: An update that misses installs the branch. It stores the upper address bits and sets the counter to 2'b10 (weak taken) for a taken outcome or 2'b01 (weak not taken) for a not-taken outcome.
- R6: An update that hits moves the counter one step: up for taken, down for not taken. The counter codes are 00 strong not taken, 01 weak not taken, 10 weak taken and 11 strong taken. A hit predicts the counter's upper bit.
- R7: The counter saturates at 2'b11 and at 2'b00.
- R8: An entry whose stored upper bits differ from the looked-up branch counts as a miss and predicts 0. An update of that branch replaces the entry.
- R9: Updates have no effect while the mode is 2'b00, 2'b01 or 2'b10.
- R10: A lookup and an update of the same index in one cycle return the state from before the update. The write takes effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Strategy select: 00 never, 01 always, 10 backward-only, 11 history table |
| pred_pc | input | 32 | Address of the branch being fetched |
| pred_offset | input | 32 | Signed byte offset to the branch target |
| pred_taken | output | 1 | Combinational direction prediction |
| upd_valid | input | 1 | A resolved branch outcome is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that mode, upd_valid and the update address and outcome are known, non-X values whenever reset is released. They also assume that an update is sampled only at a rising edge. The stimulus meets both assumptions by driving every input on the falling edge and holding it until the next falling edge. It also drives every input from the first cycle of reset. The backward-branch checks use offsets that do not wrap the address space, so "lower address" keeps its plain meaning.

// File: rtl/bp_pkg.sv
// Package: shared types for the branch direction predictor.
// Assumes: counter encoding 00 SNT, 01 WNT, 10 WT, 11 ST; prediction is bit 1.
package bp_pkg;

    typedef enum logic [1:0] {
        MODE_NEVER    = 2'b00,
        MODE_ALWAYS   = 2'b01,
        MODE_BACKWARD = 2'b10,
        MODE_TABLE    = 2'b11
    } bp_mode_e;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } bp_ctr_e;

    // Step a saturating two-bit counter toward the resolved outcome.
    function automatic bp_ctr_e ctr_step(input bp_ctr_e cur, input logic taken);
        bp_ctr_e res;
        res = cur;
        if (taken && cur != CTR_ST) begin
            res = bp_ctr_e'(cur + 2'd1);
        end else if (!taken && cur != CTR_SNT) begin
            res = bp_ctr_e'(cur - 2'd1);
        end
        return res;
    endfunction

endpackage

// File: rtl/bp_static_dir.sv
// Module: bp_static_dir
// Computes the three table-free predictions from the branch address and offset.
// Assumes: offset is two's complement; "backward" means target address < branch address.
module bp_static_dir #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    output logic            never_taken,
    output logic            always_taken,
    output logic            backward_taken
);

    logic [XLEN-1:0] target;

    // Form the target and compare it with the branch address.
    always_comb begin
        target         = pc + offset;
        never_taken    = 1'b0;
        always_taken   = 1'b1;
        backward_taken = (target < pc);
    end

endmodule

// File: rtl/bp_hist_table.sv
// Module: bp_hist_table
// Direct-mapped, tagged table of two-bit saturating counters.
// Lookup is combinational; update writes at the rising edge (read-before-write).
// Assumes: up_en is only raised when the table strategy is active.
module bp_hist_table
    import bp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_en,
    input  logic [XLEN-1:0] up_pc,
    input  logic            up_taken
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = XLEN - IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    bp_ctr_e            ctr_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             lk_hit, up_hit;
    bp_ctr_e          up_cur, up_nxt;

    // Split both addresses into index and tag fields.
    always_comb begin
        lk_idx = lk_pc[IDX_W-1:0];
        lk_tag = lk_pc[XLEN-1:IDX_W];
        up_idx = up_pc[IDX_W-1:0];
        up_tag = up_pc[XLEN-1:IDX_W];
    end

    // Lookup: a hit predicts the counter's upper bit, a miss predicts not taken.
    always_comb begin
        lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_taken = lk_hit && ctr_q[lk_idx][1];
    end

    // Update next state: step on a hit, install a weak state on a miss.
    always_comb begin
        up_hit = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
        up_cur = ctr_q[up_idx];
        if (up_hit) begin
            up_nxt = ctr_step(up_cur, up_taken);
        end else begin
            up_nxt = up_taken ? CTR_WT : CTR_WNT;
        end
    end

    // Valid bits: cleared by reset, set by any update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (up_en) begin
            valid_q[up_idx] <= 1'b1;
        end
    end

    // Tag and counter storage: written on update, no reset needed behind valid.
    always_ff @(posedge clk) begin
        if (rst_n && up_en) begin
            tag_q[up_idx] <= up_tag;
            ctr_q[up_idx] <= up_nxt;
        end
    end

    // R5: a missing branch is installed with a weak state.
    a_r5_miss_installs_weak: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !up_hit) |=> (valid_q[$past(up_idx)] &&
            (ctr_q[$past(up_idx)] == CTR_WT || ctr_q[$past(up_idx)] == CTR_WNT)));

    // R6: a taken hit below strong taken climbs one step.
    a_r6_taken_climbs: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_hit && up_taken && up_cur != CTR_ST)
            |=> (ctr_q[$past(up_idx)] == bp_ctr_e'($past(up_cur) + 2'd1)));

    // R7: saturation at both ends.
    a_r7_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_hit && up_taken && up_cur == CTR_ST) |=> (ctr_q[$past(up_idx)] == CTR_ST));
    a_r7_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_hit && !up_taken && up_cur == CTR_SNT) |=> (ctr_q[$past(up_idx)] == CTR_SNT));

    // R9: without an enabled update the valid bits do not move.
    a_r9_no_update_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !up_en |=> $stable(valid_q));

    // R4: a miss never predicts taken.
    a_r4_miss_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q[lk_idx] |-> !lk_taken);

endmodule

// File: rtl/bp_dir_predictor.sv
// Module: bp_dir_predictor (top)
// Selects among four direction strategies with a static mode input and
// routes resolved outcomes to the history table when it is the active strategy.
// Assumes: mode changes only between branches; updates are single-cycle pulses.
module bp_dir_predictor
    import bp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic [XLEN-1:0] pred_pc,
    input  logic [XLEN-1:0] pred_offset,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [XLEN-1:0] upd_pc,
    input  logic            upd_taken
);

    logic     st_never, st_always, st_backward, tbl_taken, tbl_upd_en;
    bp_mode_e mode_e;

    bp_static_dir #(.XLEN(XLEN)) u_static (
        .pc             (pred_pc),
        .offset         (pred_offset),
        .never_taken    (st_never),
        .always_taken   (st_always),
        .backward_taken (st_backward)
    );

    bp_hist_table #(.XLEN(XLEN), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (pred_pc),
        .lk_taken (tbl_taken),
        .up_en    (tbl_upd_en),
        .up_pc    (upd_pc),
        .up_taken (upd_taken)
    );

    // Gate training to the table strategy only.
    always_comb begin
        mode_e     = bp_mode_e'(mode);
        tbl_upd_en = upd_valid && (mode_e == MODE_TABLE);
    end

    // Pick the active strategy's prediction.
    always_comb begin
        unique case (mode_e)
            MODE_NEVER:    pred_taken = st_never;
            MODE_ALWAYS:   pred_taken = st_always;
            MODE_BACKWARD: pred_taken = st_backward;
            default:       pred_taken = tbl_taken;
        endcase
    end

    // R1, R2: fixed strategies drive a fixed answer.
    a_r1_never: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> !pred_taken);
    a_r2_always: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> pred_taken);
    // R3: a non-negative offset is never backward.
    a_r3_forward_nt: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !pred_offset[XLEN-1]) |-> !pred_taken);
    // R9: static modes never enable training.
    a_r9_static_no_train: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11) |-> !tbl_upd_en);

endmodule

// File: tb/test_bp_dir_predictor.sv
module test_bp_dir_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic [31:0] pred_pc = '0;
    logic [31:0] pred_offset = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bp_dir_predictor i_bp_dir_predictor (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .pred_pc(pred_pc), .pred_offset(pred_offset), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // Vector: {mode[1:0], pc[31:0], offset[31:0], expected}
    localparam int NV = 10;
    localparam logic [66:0] VEC [NV] = '{
        {2'b00, 32'h0000_1000, 32'hFFFF_FFF0, 1'b0},  // R1 backward offset
        {2'b00, 32'h0000_2000, 32'h0000_0040, 1'b0},  // R1 forward offset
        {2'b01, 32'h0000_1000, 32'h0000_0040, 1'b1},  // R2 forward offset
        {2'b01, 32'h0000_3000, 32'hFFFF_FF00, 1'b1},  // R2 backward offset
        {2'b10, 32'h0000_1000, 32'hFFFF_FFF8, 1'b1},  // R3 small backward
        {2'b10, 32'h8000_0000, 32'hF000_0000, 1'b1},  // R3 large backward
        {2'b10, 32'h0000_1000, 32'h0000_0008, 1'b0},  // R3 forward
        {2'b10, 32'h0000_1000, 32'h0000_0000, 1'b0},  // R3 zero offset
        {2'b10, 32'h0000_1000, 32'h7000_0000, 1'b0},  // R3 large forward
        {2'b11, 32'h0000_0ABC, 32'hFFFF_FFF0, 1'b0}   // R4 empty table
    };

    task automatic check(input logic exp, input string req);
        checks++;
        if (pred_taken !== exp) begin
            fails++;
            $display("FAIL %s: pred_taken=%0b expected %0b", req, pred_taken, exp);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic exp, input string req);
        @(negedge clk);
        pred_pc = pc;
        pred_offset = 32'h0000_0010;
        #1;
        check(exp, req);
    endtask

    task automatic train(input logic [31:0] pc, input logic tk);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = tk;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    localparam logic [31:0] PA = 32'h0000_1234;
    localparam logic [31:0] PB = 32'h0000_5234;  // same index as PA
    localparam logic [31:0] PC = 32'h0000_0100;
    localparam logic [31:0] PD = 32'h0000_0200;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1..R4: vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode        = VEC[i][66:65];
            pred_pc     = VEC[i][64:33];
            pred_offset = VEC[i][32:1];
            #1;
            check(VEC[i][0], "R1/R2/R3/R4 vector");
        end

        mode = 2'b11;
        look(PA, 1'b0, "R4 miss after reset");
        train(PA, 1'b1);
        look(PA, 1'b1, "R5 install taken -> WT");
        train(PA, 1'b0);
        look(PA, 1'b0, "R6 step down to WNT");
        train(PA, 1'b0);
        train(PA, 1'b0);
        train(PA, 1'b1);
        look(PA, 1'b0, "R7 saturate at SNT");
        train(PA, 1'b1);
        look(PA, 1'b1, "R6 step up to WT");
        train(PA, 1'b1);
        train(PA, 1'b1);
        train(PA, 1'b0);
        look(PA, 1'b1, "R7 saturate at ST");

        // R5: not-taken install gives weak not taken
        train(PD, 1'b0);
        look(PD, 1'b0, "R5 install not-taken");
        train(PD, 1'b1);
        look(PD, 1'b1, "R5 WNT plus taken -> WT");

        // R8: alias in the same slot
        look(PB, 1'b0, "R8 tag mismatch misses");
        train(PB, 1'b1);
        look(PB, 1'b1, "R8 alias replaces entry");
        look(PA, 1'b0, "R8 evicted branch misses");

        // R9: updates in static modes ignored
        mode = 2'b00;
        train(PC, 1'b1);
        mode = 2'b01;
        train(PC, 1'b1);
        mode = 2'b10;
        train(PC, 1'b1);
        mode = 2'b11;
        look(PC, 1'b0, "R9 static-mode update ignored");

        // R10: same-cycle lookup and update
        @(negedge clk);
        pred_pc   = PC;
        upd_valid = 1'b1;
        upd_pc    = PC;
        upd_taken = 1'b1;
        #1;
        check(1'b0, "R10 old state visible");
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        check(1'b1, "R10 write at edge");

        // R4: reset clears all entries
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(PB, 1'b0, "R4 reset invalidates");
        look(PD, 1'b0, "R4 reset invalidates");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(8 * 200000);
        join_any
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule